// File: doc/BRIEF.md
# Programmable Lane-State Instruction Sequencer

This block walks a serial display link through a short program of lane states. Software fills sixteen instruction slots with control words (lane mode, escape entry code, packet kind, clock-lane enable and data-lane enables). It also fills a successor table that says which slot follows which, a jump rule that can bend the chain a set number of times, and a pair of dwell counts. It then sets a start bit. From slot 0 the sequencer presents each slot's fields on registered outputs for a dwell period. It then moves to the next slot, and it finishes when the next slot is the terminating slot 15.

The start bit shows on `run_active`, which stays high while the program runs and drops by itself at the end. Writing zero to the control register stops a run at once. If a chain runs too long without reaching slot 15, it is cut off and a sticky error flag is raised. Lane signalling itself, the PHY and packet payloads belong to other blocks.

Top module: `lane_prog_sequencer`

## Requirements
- R1: After synchronous reset `run_active` and `chain_err` are 0, `slot_id` is 15 and every slot field output is 0.
- R2: A write of 1 to bit 0 of the control register (address 0) while idle sets `run_active` and presents slot 0 from the next cycle.
- R3: A slot word written at address 16+n drives, while slot n runs, `lane_mode` from bits [31:28], `esc_code` from [27:24], `pkt_kind` from [23:20], `clk_lane_en` from bit 4 and `data_lane_en` from [3:0].
- R4: A slot whose lane mode is not 5 (no-operation) is presented for N0+1 cycles, where N0 is bits [11:0] of the dwell register (address 2).
- R5: A slot whose lane mode is 5 is presented for N1+1 cycles, where N1 is bits [27:16] of the dwell register.
- R6: The successor of slot n is field [4(n mod 8)+3 : 4(n mod 8)] of the successor register at address 4 + n/8.
- R7: The jump register (address 1) holds a count in [15:0], a trigger slot in [19:16] and a target slot in [23:20]. While the count is nonzero, leaving the trigger slot goes to the target slot and the count decrements. The count reloads at every start.
- R8: When the next slot would be 15, `run_active` drops in that cycle, `slot_id` returns to 15 and the field outputs return to 0.
- R9: A write of 0 to bit 0 of the control register during a run stops it in the next cycle, with outputs as in R8.
- R10: A start write during a run is ignored, and the program continues unchanged.
- R11: A run whose 256th transition does not reach slot 15 stops as in R8 and sets `chain_err`, which stays set until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 32 | Register write data |
| run_active | output | 1 | Start bit readback; high while a program runs |
| chain_err | output | 1 | Sticky over-length chain flag |
| slot_id | output | 4 | Slot currently presented (15 when idle) |
| lane_mode | output | 4 | Lane mode of the current slot |
| esc_code | output | 4 | Escape entry code of the current slot |
| pkt_kind | output | 4 | Packet kind (0 pixel, 1 command) of the current slot |
| clk_lane_en | output | 1 | Clock-lane enable of the current slot |
| data_lane_en | output | 4 | Data-lane enables of the current slot |

## Verification
The bench builds the block with its default parameters: sixteen 4-bit slot identifiers, 12-bit dwell counts, a 16-bit jump count and a 256-transition step limit. It keeps the dwell counts between 0 and 4 so that a looping chain reaches the step limit within a few hundred cycles. It can therefore drive a two-slot ring into the error path and also let random successor tables either finish or overrun. The small jump counts make the reload of the count at a second start visible in a single short chain.

// File: rtl/lseq_pkg.sv
`timescale 1ns/1ps
package lseq_pkg;
  typedef enum logic [3:0] {
    LM_STOP    = 4'd0,
    LM_HS      = 4'd1,
    LM_ESC     = 4'd2,
    LM_HSCEXIT = 4'd3,
    LM_TURN    = 4'd4,
    LM_NOP     = 4'd5
  } lane_mode_t;

  // compact slot word kept in the slot memory
  typedef struct packed {
    logic [3:0] mode;
    logic [3:0] esc;
    logic [3:0] pkt;
    logic       clk_en;
    logic [3:0] dat_en;
  } slot_cfg_t;

  localparam int A_CTRL  = 0;
  localparam int A_JUMP  = 1;
  localparam int A_DWELL = 2;
  localparam int A_SUCC0 = 4;
endpackage

// File: rtl/lseq_regs.sv
`timescale 1ns/1ps
module lseq_regs
  import lseq_pkg::*;
#(
  parameter int ID_W   = 4,
  parameter int CNT_W  = 12,
  parameter int JCNT_W = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [ID_W:0]             wr_addr,
  input  logic [31:0]               wr_data,
  input  logic                      rd_ld,
  input  logic                      rd_clr,
  input  logic [ID_W-1:0]           rd_slot,
  output slot_cfg_t                 word_q,
  output logic [(2**ID_W)*ID_W-1:0] succ_flat,
  output logic [ID_W-1:0]           jmp_trig,
  output logic [ID_W-1:0]           jmp_tgt,
  output logic [JCNT_W-1:0]         jmp_cnt,
  output logic [CNT_W-1:0]          dwell_n0,
  output logic [CNT_W-1:0]          dwell_n1
);
  localparam int SLOTS = 2**ID_W;
  localparam int SUCC_BITS = SLOTS*ID_W;
  localparam int NSUCC = (SUCC_BITS + 31) / 32;

  slot_cfg_t cfg_mem [SLOTS];
  logic [NSUCC*32-1:0] succ_q;
  logic slot_wr;

  assign slot_wr = wr_en && wr_addr[ID_W];
  assign succ_flat = succ_q[SUCC_BITS-1:0];

  // slot memory: no reset, single write port, registered read
  always_ff @(posedge clk) begin
    if (slot_wr)
      cfg_mem[wr_addr[ID_W-1:0]] <= '{mode: wr_data[31:28], esc: wr_data[27:24],
                                      pkt: wr_data[23:20], clk_en: wr_data[4],
                                      dat_en: wr_data[3:0]};
  end

  always_ff @(posedge clk) begin
    if (rst)         word_q <= '0;
    else if (rd_clr) word_q <= '0;
    else if (rd_ld)  word_q <= cfg_mem[rd_slot];
  end

  generate
    for (genvar k = 0; k < NSUCC; k++) begin : g_succ
      always_ff @(posedge clk) begin
        if (rst)
          succ_q[k*32 +: 32] <= '0;
        else if (wr_en && wr_addr == (ID_W+1)'(A_SUCC0 + k))
          succ_q[k*32 +: 32] <= wr_data;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      jmp_trig <= '0;
      jmp_tgt  <= '0;
      jmp_cnt  <= '0;
      dwell_n0 <= '0;
      dwell_n1 <= '0;
    end else if (wr_en && wr_addr == (ID_W+1)'(A_JUMP)) begin
      jmp_cnt  <= wr_data[JCNT_W-1:0];
      jmp_trig <= wr_data[16 +: ID_W];
      jmp_tgt  <= wr_data[20 +: ID_W];
    end else if (wr_en && wr_addr == (ID_W+1)'(A_DWELL)) begin
      dwell_n0 <= wr_data[CNT_W-1:0];
      dwell_n1 <= wr_data[16 +: CNT_W];
    end
  end
endmodule

// File: rtl/lseq_next.sv
`timescale 1ns/1ps
module lseq_next #(
  parameter int ID_W   = 4,
  parameter int JCNT_W = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ID_W-1:0]           cur,
  input  logic [(2**ID_W)*ID_W-1:0] succ_flat,
  input  logic [ID_W-1:0]           jmp_trig,
  input  logic [ID_W-1:0]           jmp_tgt,
  input  logic [JCNT_W-1:0]         jmp_init,
  input  logic                      ld,
  input  logic                      adv,
  output logic [ID_W-1:0]           nxt
);
  logic [JCNT_W-1:0] jleft;
  logic take_jump;

  assign take_jump = (cur == jmp_trig) && (jleft != '0);

  always_comb begin
    if (take_jump) nxt = jmp_tgt;
    else           nxt = succ_flat[32'(cur)*ID_W +: ID_W];
  end

  always_ff @(posedge clk) begin
    if (rst)                    jleft <= '0;
    else if (ld)                jleft <= jmp_init;
    else if (adv && take_jump)  jleft <= jleft - 1'b1;
  end

  // R7
  jump_cnt_mono_chk: assert property (@(posedge clk) disable iff (rst)
    !ld |=> (jleft <= $past(jleft)));
endmodule

// File: rtl/lseq_ctrl.sv
`timescale 1ns/1ps
module lseq_ctrl
  import lseq_pkg::*;
#(
  parameter int ID_W      = 4,
  parameter int CNT_W     = 12,
  parameter int MAX_STEPS = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_wr,
  input  logic             ctl_bit,
  input  logic [ID_W-1:0]  nxt,
  input  logic [3:0]       mode_cur,
  input  logic [CNT_W-1:0] n0,
  input  logic [CNT_W-1:0] n1,
  output logic             running,
  output logic             err,
  output logic [ID_W-1:0]  cur,
  output logic             adv,
  output logic             launch,
  output logic             ld_word,
  output logic             clr_word,
  output logic [ID_W-1:0]  rd_slot
);
  localparam logic [ID_W-1:0] TERM = ID_W'(2**ID_W - 1);
  localparam int STEP_W = $clog2(MAX_STEPS) + 1;

  logic [CNT_W-1:0]  dwell;
  logic [CNT_W-1:0]  limit;
  logic [STEP_W-1:0] steps;
  logic at_end, abort, finish, overrun;

  assign limit   = (mode_cur == LM_NOP) ? n1 : n0;
  assign at_end  = running && (dwell == limit);
  assign launch  = ctl_wr && ctl_bit && !running;
  assign abort   = ctl_wr && !ctl_bit && running;
  assign adv     = at_end && !abort;
  assign finish  = adv && (nxt == TERM);
  assign overrun = adv && (nxt != TERM) && (steps == STEP_W'(MAX_STEPS - 1));
  assign rd_slot  = launch ? '0 : nxt;
  assign ld_word  = launch || (adv && !finish && !overrun);
  assign clr_word = abort || finish || overrun;

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      err     <= 1'b0;
      cur     <= TERM;
      dwell   <= '0;
      steps   <= '0;
    end else if (launch) begin
      running <= 1'b1;
      err     <= 1'b0;
      cur     <= '0;
      dwell   <= '0;
      steps   <= '0;
    end else if (clr_word) begin
      running <= 1'b0;
      cur     <= TERM;
      dwell   <= '0;
      if (overrun) err <= 1'b1;
    end else if (adv) begin
      cur   <= nxt;
      dwell <= '0;
      steps <= steps + 1'b1;
    end else if (running) begin
      dwell <= dwell + 1'b1;
    end
  end

  // R2
  launch_slot0_chk: assert property (@(posedge clk) disable iff (rst)
    launch |=> (running && cur == '0));
  // R9
  abort_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && !ctl_bit && running) |=> (!running && cur == TERM));
  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && ctl_bit && running && !at_end) |=> (running && $stable(cur)));
  // R11
  err_halt_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> !running);
endmodule

// File: rtl/lane_prog_sequencer.sv
`timescale 1ns/1ps
module lane_prog_sequencer
  import lseq_pkg::*;
#(
  parameter int ID_W      = 4,
  parameter int CNT_W     = 12,
  parameter int JCNT_W    = 16,
  parameter int MAX_STEPS = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [ID_W:0]    wr_addr,
  input  logic [31:0]      wr_data,
  output logic             run_active,
  output logic             chain_err,
  output logic [ID_W-1:0]  slot_id,
  output logic [3:0]       lane_mode,
  output logic [3:0]       esc_code,
  output logic [3:0]       pkt_kind,
  output logic             clk_lane_en,
  output logic [3:0]       data_lane_en
);
  localparam int SLOTS = 2**ID_W;

  slot_cfg_t word_q;
  logic [SLOTS*ID_W-1:0] succ_flat;
  logic [ID_W-1:0] jmp_trig, jmp_tgt, nxt, cur, rd_slot;
  logic [JCNT_W-1:0] jmp_cnt;
  logic [CNT_W-1:0] n0, n1;
  logic ctl_wr, adv, launch, ld_word, clr_word;

  assign ctl_wr = wr_en && (wr_addr == (ID_W+1)'(A_CTRL));

  lseq_regs #(.ID_W(ID_W), .CNT_W(CNT_W), .JCNT_W(JCNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_ld(ld_word), .rd_clr(clr_word), .rd_slot(rd_slot), .word_q(word_q),
    .succ_flat(succ_flat), .jmp_trig(jmp_trig), .jmp_tgt(jmp_tgt),
    .jmp_cnt(jmp_cnt), .dwell_n0(n0), .dwell_n1(n1));

  lseq_next #(.ID_W(ID_W), .JCNT_W(JCNT_W)) u_next (
    .clk(clk), .rst(rst), .cur(cur), .succ_flat(succ_flat),
    .jmp_trig(jmp_trig), .jmp_tgt(jmp_tgt), .jmp_init(jmp_cnt),
    .ld(launch), .adv(adv), .nxt(nxt));

  lseq_ctrl #(.ID_W(ID_W), .CNT_W(CNT_W), .MAX_STEPS(MAX_STEPS)) u_ctrl (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_bit(wr_data[0]), .nxt(nxt),
    .mode_cur(word_q.mode), .n0(n0), .n1(n1), .running(run_active),
    .err(chain_err), .cur(cur), .adv(adv), .launch(launch),
    .ld_word(ld_word), .clr_word(clr_word), .rd_slot(rd_slot));

  assign slot_id      = cur;
  assign lane_mode    = word_q.mode;
  assign esc_code     = word_q.esc;
  assign pkt_kind     = word_q.pkt;
  assign clk_lane_en  = word_q.clk_en;
  assign data_lane_en = word_q.dat_en;

  // R8
  idle_blank_chk: assert property (@(posedge clk) disable iff (rst)
    !run_active |-> (word_q == '0));
  // R1
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (!run_active && !chain_err && slot_id == ID_W'(SLOTS-1)));
endmodule

// File: tb/sim_lane_prog_sequencer.sv
`timescale 1ns/1ps
module sim_lane_prog_sequencer;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [4:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic run_active, chain_err, clk_lane_en;
  logic [3:0] slot_id, lane_mode, esc_code, pkt_kind, data_lane_en;

  lane_prog_sequencer u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .run_active(run_active), .chain_err(chain_err), .slot_id(slot_id),
    .lane_mode(lane_mode), .esc_code(esc_code), .pkt_kind(pkt_kind),
    .clk_lane_en(clk_lane_en), .data_lane_en(data_lane_en));

  always #(CLK_PERIOD/2) clk = ~clk;

  bit [31:0] cfg [16];
  bit [3:0]  succ [16];
  bit [3:0]  jtrig, jtgt;
  bit [15:0] jcnt;
  bit [11:0] n0, n1;
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  function automatic logic [31:0] obs();
    return {9'b0, run_active, chain_err, slot_id, lane_mode, esc_code, pkt_kind,
            clk_lane_en, data_lane_en};
  endfunction

  function automatic logic [31:0] exp_busy(int s);
    return {9'b0, 1'b1, 1'b0, 4'(s), cfg[s][31:20], cfg[s][4:0]};
  endfunction

  function automatic logic [31:0] exp_idle(bit e);
    return {9'b0, 1'b0, e, 4'hF, 17'b0};
  endfunction

  function automatic int dwell_of(int s);
    return (cfg[s][31:28] == 4'd5) ? int'(n1) + 1 : int'(n0) + 1;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'(addr); wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load_all();
    logic [31:0] lo, hi;
    for (int i = 0; i < 16; i++) wr(16 + i, cfg[i]);
    for (int i = 0; i < 8; i++) begin
      lo[4*i +: 4] = succ[i];
      hi[4*i +: 4] = succ[8 + i];
    end
    wr(4, lo);
    wr(5, hi);
    wr(1, {8'h0, jtgt, jtrig, jcnt});
    wr(2, {4'h0, n1, 4'h0, n0});
  endtask

  // runs one program against the model; poke_at injects a start write (R10),
  // abort_at injects a stop write (R9); -1 disables either
  task automatic run_seq(input int poke_at, input int abort_at);
    int s, trans, cyc, nxt;
    bit [15:0] jc;
    string req;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'd0; wr_data = 32'd1;
    @(posedge clk); #1;
    wr_en = 1'b0;
    s = 0; jc = jcnt; trans = 0; cyc = 0;
    forever begin
      for (int d = 0; d < dwell_of(s); d++) begin
        req = (cfg[s][31:28] == 4'd5) ? "R2,R3,R5,R6" : "R2,R3,R4,R6";
        if (poke_at >= 0 && cyc == poke_at + 1) req = "R10";
        chk(req, obs(), exp_busy(s));
        if (cyc == abort_at) begin
          wr_en = 1'b1; wr_addr = 5'd0; wr_data = 32'd0;
          @(posedge clk); #1;
          wr_en = 1'b0;
          chk("R9", obs(), exp_idle(1'b0));
          return;
        end
        if (cyc == poke_at) begin
          wr_en = 1'b1; wr_addr = 5'd0; wr_data = 32'd1;
        end
        @(posedge clk); #1;
        wr_en = 1'b0;
        cyc++;
      end
      if (s == int'(jtrig) && jc != 0) begin
        nxt = int'(jtgt); jc--;
      end else begin
        nxt = int'(succ[s]);
      end
      if (nxt == 15) begin
        chk("R8", obs(), exp_idle(1'b0));
        return;
      end
      if (trans == 255) begin
        chk("R11", obs(), exp_idle(1'b1));
        return;
      end
      trans++;
      s = nxt;
    end
  endtask

  task automatic clear_tables();
    for (int i = 0; i < 16; i++) begin
      cfg[i] = 32'h0;
      succ[i] = 4'hF;
    end
    jtrig = 4'd0; jtgt = 4'd0; jcnt = 16'd0; n0 = 12'd0; n1 = 12'd0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", obs(), exp_idle(1'b0));

    // directed chain 0 -> 3 -> 7 -> end, slot 7 is a no-operation slot
    clear_tables();
    cfg[0] = 32'h0000_001F;
    cfg[3] = 32'h1A30_0013;
    cfg[7] = 32'h5120_0008;
    succ[0] = 4'd3; succ[3] = 4'd7; succ[7] = 4'd15;
    n0 = 12'd2; n1 = 12'd4;
    load_all();
    run_seq(-1, -1);

    // jump rule: 0 -> 1 -> 3, trigger 3 target 1 twice; run twice for reload (R7)
    clear_tables();
    cfg[0] = 32'h0000_0010; cfg[1] = 32'h2410_0001; cfg[3] = 32'h3000_0010;
    succ[0] = 4'd1; succ[1] = 4'd3; succ[3] = 4'd15;
    jtrig = 4'd3; jtgt = 4'd1; jcnt = 16'd2; n0 = 12'd1;
    load_all();
    run_seq(-1, -1);
    run_seq(-1, -1);
    chk("R7", obs(), exp_idle(1'b0));

    // start write while busy is ignored (R10)
    n0 = 12'd3;
    wr(2, {4'h0, n1, 4'h0, n0});
    run_seq(2, -1);

    // abort in mid run (R9)
    run_seq(-1, 5);
    repeat (3) @(posedge clk);
    #1;
    chk("R9", obs(), exp_idle(1'b0));

    // endless ring 0 <-> 1 reaches the step limit (R11)
    clear_tables();
    cfg[0] = 32'h1000_0001; cfg[1] = 32'h4000_0003;
    succ[0] = 4'd1; succ[1] = 4'd0;
    load_all();
    run_seq(-1, -1);
    repeat (5) @(posedge clk);
    #1;
    chk("R11", obs(), exp_idle(1'b1));
    succ[1] = 4'd15;
    wr(4, {24'hFFFFFF, 4'd15, 4'd1});
    run_seq(-1, -1);
    chk("R11", obs(), exp_idle(1'b0));

    // constrained random programs
    for (int r = 0; r < 25; r++) begin
      for (int i = 0; i < 16; i++) begin
        cfg[i] = $urandom;
        cfg[i][31:28] = 4'($urandom % 6);
        succ[i] = (($urandom % 4) == 0) ? 4'd15 : 4'($urandom % 16);
      end
      jtrig = 4'($urandom % 15);
      jtgt  = 4'($urandom % 15);
      jcnt  = 16'($urandom % 4);
      n0    = 12'($urandom % 4);
      n1    = 12'($urandom % 4);
      load_all();
      run_seq(-1, -1);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule